// File: doc/BRIEF.md
# Raw NAND Flash Command Sequencer

This block sits on the host side of an 8-bit raw NAND flash bus. It accepts one operation at a time through a valid/ready request port and produces the chip-enable, command-latch, address-latch, write-strobe and read-strobe sequences that the operation needs. Five operations are supported: device reset, identifier read, a single status read, block erase and page program. For a program operation the write bytes are pulled from the requester one at a time over a small handshake. Bytes read back from the device are pushed out on a one-cycle strobe.

After an erase or a program, the sequencer sends the status command once. It then re-pulses only the read strobe, reading the status byte again until the ready bit is set, a timeout count runs out, or the requester asks for an abort. An abort sends the reset command to the flash. Every operation ends with a single-cycle done pulse. The result flags (program/erase failure, write protection, timeout and abort) are valid in that cycle.

Bus timing comes from two clock-count parameters: the low time and the high time of every strobe pulse. The timeout limits are also given in clock cycles.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high, and `req_ready` is high only when the sequencer is idle. `nand_ce_n` is low in every cycle from acceptance up to, but not including, the done cycle. It is high while idle and during the done cycle.
- R2: Every bus cycle drives its strobe (`nand_we_n` for command, address and write-data cycles; `nand_re_n` for reads) low for TLOW clocks and then high for at least THIGH clocks. `nand_dq_o`, `nand_cle` and `nand_ale` stay unchanged while `nand_we_n` is low and on its rising edge. `nand_dq_oe` is high exactly during write-type cycles.
- R3: Opcode 0 (reset) issues one cycle with CLE high and data FFh, then completes with every result flag low.
- R4: Opcode 1 (identifier read) issues 90h with CLE high, then one cycle of 00h with ALE high, then ID_BYTES read strobes. Each byte is presented on `rd_data` with a `rd_valid` pulse and is sampled on the last clock before the strobe rises.
- R5: Opcode 2 (status read) issues 70h and one read strobe, and returns the byte on `rd_data`. Done then reports `sts_fail` = bit 0 of that byte and `sts_wp` = inverse of bit 7 (bit 7 = 1 means writes are enabled).
- R6: Opcode 3 (block erase) issues 60h, then the ROW_CYC bytes of `req_row` with ALE high (least significant byte first), then D0h with CLE high.
- R7: Opcode 4 (page program) issues 80h, then the COL_CYC bytes of `req_col` and then the ROW_CYC bytes of `req_row` with ALE high (each least significant byte first). It then sends each write byte taken on a `wr_valid`/`wr_ready` handshake with CLE and ALE low, up to and including the byte marked `wr_last`, and finally issues 10h.
- R8: After an erase or program confirm, 70h is issued exactly once. Read strobes then repeat until a status byte has bit 6 (ready) set. Done reports `sts_fail` = bit 0 and `sts_wp` = inverse of bit 7 of that final byte.
- R9: If polling has not seen ready within ERASE_TMO clocks (erase) or PROG_TMO clocks (program), counted from the status command, the sequencer completes with `sts_tmo` high and `sts_fail` low.
- R10: An `abort_req` pulse during status polling lets the current bus cycle finish, then issues FFh with CLE high and completes with `sts_abort` high and the other flags low. Outside polling, `abort_req` has no effect.
- R11: Opcodes 5 to 7 complete on the cycle after acceptance, with no bus cycle and all flags low.
- R12: The write strobe and the read strobe are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 3 | Operation code |
| req_row | input | 8*ROW_CYC | Row (block/page) address |
| req_col | input | 8*COL_CYC | Column address |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Marks the final write byte |
| abort_req | input | 1 | Abort pulse during polling |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation complete pulse |
| sts_fail | output | 1 | Program/erase or status fail bit |
| sts_wp | output | 1 | Device is write protected |
| sts_tmo | output | 1 | Polling timed out |
| sts_abort | output | 1 | Operation aborted with reset |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |

## Verification
A wrong state in the sequencer shows up within one strobe period as an out-of-order or missing command or address byte in the captured write-cycle log, or as a strobe pulse of the wrong width. The bench compares that log byte by byte against a sequence it builds from the opcode and address. A fault in the polling or abort path shows up when the operation completes: the count of read strobes differs from the number of busy responses plus one, or the done flags disagree with the final status byte or the expected timeout or abort.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // Operation codes on req_op
  localparam logic [2:0] OP_RESET   = 3'd0;
  localparam logic [2:0] OP_READID  = 3'd1;
  localparam logic [2:0] OP_STATUS  = 3'd2;
  localparam logic [2:0] OP_ERASE   = 3'd3;
  localparam logic [2:0] OP_PROGRAM = 3'd4;

  // Bytes placed on the bus during command cycles
  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] CMD_READID   = 8'h90;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;

  // Status byte bit positions
  localparam int ST_FAIL = 0;
  localparam int ST_RDY  = 6;
  localparam int ST_WEN  = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WLOAD, S_WDATA, S_CMD2,
    S_STCMD, S_STRD, S_IDRD, S_ABORT, S_DONE
  } seq_state_e;

  function automatic logic [7:0] lead_cmd(input logic [2:0] op);
    case (op)
      OP_RESET:   lead_cmd = CMD_RESET;
      OP_READID:  lead_cmd = CMD_READID;
      OP_ERASE:   lead_cmd = CMD_ERASE;
      default:    lead_cmd = CMD_PROG;
    endcase
  endfunction

endpackage

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
  parameter int TLOW  = 2,
  parameter int THIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic low,
  output logic smp,
  output logic fin
);
  localparam int LEN = TLOW + THIGH;
  localparam int CW  = (LEN > 2) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                         cnt_d = '0;
    else if (cnt_q == CW'(LEN - 1))   cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign low = run && (cnt_q < CW'(TLOW));
  assign smp = run && (cnt_q == CW'(TLOW - 1));
  assign fin = run && (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/nand_poll_watch.sv
module nand_poll_watch #(
  parameter int TW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q < limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int TLOW      = 2,
  parameter int THIGH     = 2,
  parameter int COL_CYC   = 2,
  parameter int ROW_CYC   = 3,
  parameter int ID_BYTES  = 4,
  parameter int ERASE_TMO = 200000,
  parameter int PROG_TMO  = 70000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic [8*ROW_CYC-1:0] req_row,
  input  logic [8*COL_CYC-1:0] req_col,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [7:0]           wr_data,
  input  logic                 wr_last,
  input  logic                 abort_req,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 done,
  output logic                 sts_fail,
  output logic                 sts_wp,
  output logic                 sts_tmo,
  output logic                 sts_abort,
  output logic                 nand_ce_n,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic                 nand_re_n,
  output logic [7:0]           nand_dq_o,
  output logic                 nand_dq_oe,
  input  logic [7:0]           nand_dq_i
);
  localparam int ADR_CYC = COL_CYC + ROW_CYC;
  localparam int AW      = (ADR_CYC > 2) ? $clog2(ADR_CYC) : 1;
  localparam int IW      = (ID_BYTES > 2) ? $clog2(ID_BYTES) : 1;
  localparam int TMO_MAX = (ERASE_TMO > PROG_TMO) ? ERASE_TMO : PROG_TMO;
  localparam int TW      = $clog2(TMO_MAX + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_state_e             state_q, state_d;
  logic [2:0]             op_q, op_d;
  logic [8*ADR_CYC-1:0]   adr_q, adr_d;
  logic [AW-1:0]          aidx_q, aidx_d;
  logic [IW-1:0]          iidx_q, iidx_d;
  logic [7:0]             wbyte_q, wbyte_d, stat_q, stat_d, rdd_q, rdd_d;
  logic                   wlast_q, wlast_d, abt_q, abt_d;
  logic                   rtmo_q, rtmo_d, rabt_q, rabt_d, rdv_q, rdv_d;

  logic bus_cyc, is_wr, is_rd, polling, low, smp, fin, expired, uses_st;
  logic [TW-1:0] limit;

  assign is_wr   = (state_q == S_CMD1) || (state_q == S_ADDR) || (state_q == S_WDATA) ||
                   (state_q == S_CMD2) || (state_q == S_STCMD) || (state_q == S_ABORT);
  assign is_rd   = (state_q == S_STRD) || (state_q == S_IDRD);
  assign bus_cyc = is_wr || is_rd;
  assign polling = (state_q == S_STCMD) || (state_q == S_STRD);
  assign limit   = (op_q == OP_ERASE) ? TW'(ERASE_TMO) : TW'(PROG_TMO);

  nand_cycle_timer #(.TLOW(TLOW), .THIGH(THIGH)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .run(bus_cyc), .low(low), .smp(smp), .fin(fin));

  nand_poll_watch #(.TW(TW)) u_watch (
    .clk(clk), .rst_n(rst_i_n), .run(polling), .limit(limit), .expired(expired));

  // Next-state process
  always_comb begin
    state_d = state_q;  op_d = op_q;     adr_d = adr_q;   aidx_d = aidx_q;
    iidx_d  = iidx_q;   wbyte_d = wbyte_q; wlast_d = wlast_q; stat_d = stat_q;
    abt_d   = abt_q;    rtmo_d = rtmo_q; rabt_d = rabt_q; rdd_d = rdd_q;
    rdv_d   = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        op_d   = req_op;
        adr_d  = {req_row, req_col};
        aidx_d = (req_op == OP_ERASE) ? AW'(COL_CYC) : '0;
        iidx_d = '0;
        abt_d  = 1'b0;
        rtmo_d = 1'b0;
        rabt_d = 1'b0;
        case (req_op)
          OP_RESET, OP_READID, OP_ERASE, OP_PROGRAM: state_d = S_CMD1;
          OP_STATUS:                                 state_d = S_STCMD;
          default:                                   state_d = S_DONE;
        endcase
      end
      S_CMD1:  if (fin) state_d = (op_q == OP_RESET) ? S_DONE : S_ADDR;
      S_ADDR:  if (fin) begin
        if (op_q == OP_READID)                state_d = S_IDRD;
        else if (aidx_q == AW'(ADR_CYC - 1))  state_d = (op_q == OP_ERASE) ? S_CMD2 : S_WLOAD;
        else                                  aidx_d  = aidx_q + 1'b1;
      end
      S_WLOAD: if (wr_valid) begin
        wbyte_d = wr_data;
        wlast_d = wr_last;
        state_d = S_WDATA;
      end
      S_WDATA: if (fin) state_d = wlast_q ? S_CMD2 : S_WLOAD;
      S_CMD2:  if (fin) state_d = S_STCMD;
      S_STCMD: if (fin) state_d = abt_q ? S_ABORT : S_STRD;
      S_STRD: begin
        if (smp) begin
          stat_d = nand_dq_i;
          rdd_d  = nand_dq_i;
          rdv_d  = (op_q == OP_STATUS);
        end
        if (fin) begin
          if (abt_q)                                        state_d = S_ABORT;
          else if (stat_q[ST_RDY] || (op_q == OP_STATUS))   state_d = S_DONE;
          else if (expired) begin
            state_d = S_DONE;
            rtmo_d  = 1'b1;
          end
        end
      end
      S_IDRD: begin
        if (smp) begin
          rdd_d = nand_dq_i;
          rdv_d = 1'b1;
        end
        if (fin) begin
          if (iidx_q == IW'(ID_BYTES - 1)) state_d = S_DONE;
          else                             iidx_d  = iidx_q + 1'b1;
        end
      end
      S_ABORT: if (fin) begin
        state_d = S_DONE;
        rabt_d  = 1'b1;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (polling && abort_req && (op_q != OP_STATUS)) abt_d = 1'b1;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE;  op_q <= '0;    adr_q <= '0;   aidx_q <= '0;
      iidx_q  <= '0;      wbyte_q <= '0; wlast_q <= 1'b0; stat_q <= '0;
      abt_q   <= 1'b0;    rtmo_q <= 1'b0; rabt_q <= 1'b0; rdd_q <= '0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d; op_q <= op_d;   adr_q <= adr_d; aidx_q <= aidx_d;
      iidx_q  <= iidx_d;  wbyte_q <= wbyte_d; wlast_q <= wlast_d; stat_q <= stat_d;
      abt_q   <= abt_d;   rtmo_q <= rtmo_d; rabt_q <= rabt_d; rdd_q <= rdd_d;
      rdv_q   <= rdv_d;
    end
  end

  // Bus outputs
  always_comb begin
    unique case (state_q)
      S_CMD1:  nand_dq_o = lead_cmd(op_q);
      S_ADDR:  nand_dq_o = (op_q == OP_READID) ? 8'h00 : adr_q[int'(aidx_q)*8 +: 8];
      S_WDATA: nand_dq_o = wbyte_q;
      S_CMD2:  nand_dq_o = (op_q == OP_ERASE) ? CMD_ERASE_GO : CMD_PROG_GO;
      S_STCMD: nand_dq_o = CMD_STATUS;
      S_ABORT: nand_dq_o = CMD_RESET;
      default: nand_dq_o = 8'h00;
    endcase
  end

  assign nand_ce_n  = (state_q == S_IDLE) || (state_q == S_DONE);
  assign nand_cle   = (state_q == S_CMD1) || (state_q == S_CMD2) ||
                      (state_q == S_STCMD) || (state_q == S_ABORT);
  assign nand_ale   = (state_q == S_ADDR);
  assign nand_we_n  = !(is_wr && low);
  assign nand_re_n  = !(is_rd && low);
  assign nand_dq_oe = is_wr;

  assign req_ready = (state_q == S_IDLE);
  assign wr_ready  = (state_q == S_WLOAD);
  assign done      = (state_q == S_DONE);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  assign uses_st   = (op_q == OP_STATUS) || (op_q == OP_ERASE) || (op_q == OP_PROGRAM);
  assign sts_fail  = done && uses_st && !rabt_q && !rtmo_q && stat_q[ST_FAIL];
  assign sts_wp    = done && uses_st && !rabt_q && !stat_q[ST_WEN];
  assign sts_tmo   = done && rtmo_q;
  assign sts_abort = done && rabt_q;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       sts_tmo,
  input logic       sts_abort,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe
);
  p_ce_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);

  p_ce_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |-> !nand_ce_n);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  p_we_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)));

  p_we_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  p_re_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(sts_tmo && sts_abort));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (.*);

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
  localparam int TLOW = 2, THIGH = 2, ID_BYTES = 4, ETMO = 120, PTMO = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, wr_valid, wr_ready, wr_last, abort_req;
  logic [2:0] req_op;
  logic [23:0] req_row;
  logic [15:0] req_col;
  logic [7:0] wr_data, rd_data, nand_dq_o, dev_dq;
  logic rd_valid, done, sts_fail, sts_wp, sts_tmo, sts_abort;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;

  nand_cmd_seq #(.TLOW(TLOW), .THIGH(THIGH), .ID_BYTES(ID_BYTES),
                 .ERASE_TMO(ETMO), .PROG_TMO(PTMO)) u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .abort_req(abort_req), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .sts_fail(sts_fail), .sts_wp(sts_wp), .sts_tmo(sts_tmo), .sts_abort(sts_abort),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(dev_dq));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // ---- device model and bus monitor ----
  logic [9:0] act_log[$];
  logic [7:0] exp_rd[$];
  logic [7:0] last_cmd = 8'h00;
  int rd_idx = 0, poll_left = 0, re_cnt = 0, ce_low = 0;
  bit mdl_wen = 1'b1, mdl_fail = 1'b0;
  bit p_we = 1'b1, p_re = 1'b1, hold_ok = 1'b1;
  int wl = 0, wh = 100, rl = 0;
  logic [9:0] hold;

  function automatic logic [7:0] id_of(input int i);
    return 8'(8'h2C + i * 8'h3B);
  endfunction
  function automatic logic [7:0] st_busy(input bit wen);
    return {wen, 7'b0};
  endfunction
  function automatic logic [7:0] st_final(input bit wen, input bit f);
    return {wen, 1'b1, 5'b0, f};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_ce_n) ce_low++;
      if (!nand_we_n) begin
        if (p_we) begin
          chk(wh >= THIGH, "R2", "WE# high gap", wh, THIGH);
          wl = 1; hold = {nand_cle, nand_ale, nand_dq_o}; hold_ok = 1'b1;
        end else begin
          wl++;
          if ({nand_cle, nand_ale, nand_dq_o} != hold) hold_ok = 1'b0;
        end
      end else begin
        if (!p_we) begin
          chk(wl == TLOW, "R2", "WE# low width", wl, TLOW);
          chk(hold_ok, "R2", "bus stable under WE#", hold_ok, 1);
          act_log.push_back(hold);
          if (hold[9]) begin last_cmd = hold[7:0]; rd_idx = 0; end
          wh = 1;
        end else wh++;
      end
      if (!nand_re_n) rl = p_re ? 1 : rl + 1;
      else if (!p_re) begin
        chk(rl == TLOW, "R2", "RE# low width", rl, TLOW);
        re_cnt++;
        if (last_cmd == 8'h70 && poll_left > 0) poll_left--;
        if (last_cmd == 8'h90) rd_idx++;
      end
      p_we = nand_we_n; p_re = nand_re_n;
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(1'b0, "R4", "unexpected rd_valid", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R4", "read byte", rd_data, e);
        end
      end
    end
    case (last_cmd)
      8'h90:   dev_dq = id_of(rd_idx);
      8'h70:   dev_dq = (poll_left > 0) ? st_busy(mdl_wen) : st_final(mdl_wen, mdl_fail);
      default: dev_dq = 8'h00;
    endcase
  end

  // ---- operation driver and checker ----
  task automatic run_op(input logic [2:0] op, input logic [23:0] row, input logic [15:0] col,
                        input int nbytes, input int poll, input bit f, input bit wen,
                        input bit abort_it, input bit exp_tmo);
    logic [9:0] exp_log[$];
    logic [7:0] wq[$];
    bit uses_st, e_fail, e_wp;
    string rq;
    for (int i = 0; i < nbytes; i++) wq.push_back(8'($urandom));
    rq = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : (op == 3) ? "R6" : (op == 4) ? "R7" : "R11";
    case (op)
      3'd0: exp_log.push_back({2'b10, 8'hFF});
      3'd1: begin
        exp_log.push_back({2'b10, 8'h90}); exp_log.push_back({2'b01, 8'h00});
        for (int i = 0; i < ID_BYTES; i++) exp_rd.push_back(id_of(i));
      end
      3'd2: begin
        exp_log.push_back({2'b10, 8'h70});
        exp_rd.push_back((poll > 0) ? st_busy(wen) : st_final(wen, f));
      end
      3'd3: begin
        exp_log.push_back({2'b10, 8'h60});
        for (int i = 0; i < 3; i++) exp_log.push_back({2'b01, row[8*i +: 8]});
        exp_log.push_back({2'b10, 8'hD0}); exp_log.push_back({2'b10, 8'h70});
      end
      3'd4: begin
        exp_log.push_back({2'b10, 8'h80});
        for (int i = 0; i < 2; i++) exp_log.push_back({2'b01, col[8*i +: 8]});
        for (int i = 0; i < 3; i++) exp_log.push_back({2'b01, row[8*i +: 8]});
        for (int i = 0; i < nbytes; i++) exp_log.push_back({2'b00, wq[i]});
        exp_log.push_back({2'b10, 8'h10}); exp_log.push_back({2'b10, 8'h70});
      end
      default: ;
    endcase
    if (abort_it) exp_log.push_back({2'b10, 8'hFF});
    uses_st = (op == 2) || (op == 3) || (op == 4);
    e_fail  = uses_st && !abort_it && !exp_tmo && ((op == 2 && poll > 0) ? 1'b0 : f);
    e_wp    = uses_st && !abort_it && !wen;

    @(negedge clk);
    act_log.delete(); re_cnt = 0; ce_low = 0;
    poll_left = poll; mdl_wen = wen; mdl_fail = f;
    req_op = op; req_row = row; req_col = col; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    for (int i = 0; i < ((op == 4) ? nbytes : 0); i++) begin
      wr_data = wq[i]; wr_last = (i == nbytes - 1); wr_valid = 1'b1;
      do @(negedge clk); while (!wr_ready);
      @(posedge clk); #1 wr_valid = 1'b0;
    end
    if (abort_it) begin
      while (re_cnt == 0) @(negedge clk);
      abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    end
    do @(negedge clk); while (!done);

    chk(act_log.size() == exp_log.size(), rq, "write-cycle count", act_log.size(), exp_log.size());
    for (int i = 0; i < exp_log.size() && i < act_log.size(); i++)
      chk(act_log[i] == exp_log[i], (i >= exp_log.size() - 1 && abort_it) ? "R10" :
          (op >= 3 && i == exp_log.size() - 1) ? "R8" : rq, "write cycle", act_log[i], exp_log[i]);
    chk(sts_fail == e_fail, uses_st ? "R8" : rq, "sts_fail", sts_fail, e_fail);
    chk(sts_wp == e_wp, uses_st ? "R5" : rq, "sts_wp", sts_wp, e_wp);
    chk(sts_tmo == exp_tmo, "R9", "sts_tmo", sts_tmo, exp_tmo);
    chk(sts_abort == abort_it, "R10", "sts_abort", sts_abort, abort_it);
    chk(nand_ce_n == 1'b1, "R1", "CE# high at done", nand_ce_n, 1);
    if (op > 4) chk(ce_low == 0, "R11", "CE# cycles for unknown op", ce_low, 0);
    else        chk(ce_low > 0, "R1", "CE# low during op", ce_low, 1);
    if (op == 1) chk(re_cnt == ID_BYTES, "R4", "ID strobes", re_cnt, ID_BYTES);
    if (op == 2) chk(re_cnt == 1, "R5", "status strobes", re_cnt, 1);
    if ((op == 3 || op == 4) && !abort_it && !exp_tmo)
      chk(re_cnt == poll + 1, "R8", "poll strobes", re_cnt, poll + 1);
    chk(exp_rd.size() == 0, rq, "read bytes outstanding", exp_rd.size(), 0);
    exp_rd.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_row = '0; req_col = '0;
    wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0; abort_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1", "reset bus idle",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(done == 1'b0 && nand_cle == 1'b0 && nand_ale == 1'b0, "R12", "reset latches low",
        {done, nand_cle, nand_ale}, 0);

    // directed corners
    run_op(3'd0, 24'h0, 16'h0, 0, 0, 0, 1, 0, 0);              // R3 reset
    run_op(3'd1, 24'h0, 16'h0, 0, 0, 0, 1, 0, 0);              // R4 read id
    run_op(3'd2, 24'h0, 16'h0, 0, 1, 1, 0, 0, 0);              // R5 status while busy
    run_op(3'd3, 24'hA5B6C7, 16'h0, 0, 0, 1, 1, 0, 0);         // R6 erase ready at once
    run_op(3'd4, 24'h123456, 16'hBEEF, 1, 2, 0, 0, 0, 0);      // R7 single byte program
    run_op(3'd3, 24'h010203, 16'h0, 0, 1000, 0, 1, 0, 1);      // R9 erase timeout
    run_op(3'd4, 24'h0A0B0C, 16'h0D0E, 3, 1000, 0, 1, 0, 1);   // R9 program timeout
    run_op(3'd3, 24'h777777, 16'h0, 0, 1000, 0, 1, 1, 0);      // R10 abort erase
    run_op(3'd4, 24'h333333, 16'h4444, 2, 1000, 0, 1, 1, 0);   // R10 abort program
    @(negedge clk); abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    run_op(3'd2, 24'h0, 16'h0, 0, 0, 0, 1, 0, 0);              // R10 idle abort ignored
    run_op(3'd6, 24'h0, 16'h0, 0, 0, 0, 1, 0, 0);              // R11 unknown op

    // constrained random
    for (int n = 0; n < 30; n++) begin
      int k;
      logic [2:0] op;
      k  = $urandom_range(0, 5);
      op = (k == 5) ? 3'($urandom_range(5, 7)) : 3'(k);
      run_op(op, 24'($urandom), 16'($urandom), $urandom_range(1, 6), $urandom_range(0, 3),
             1'($urandom), 1'($urandom), 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule